// File: doc/BRIEF.md
# DDR2 Write Burst Sequencer

This block sits on the controller side of a DDR2-style memory channel and turns one user write request into a write command followed by a scheduled double-data-rate burst. A request carries a bank, a starting column and up to eight data beats. Once it is accepted, the block drives the write command on the command pins. It then raises per-clock enable flags for the PHY: one clock of strobe preamble, the strobe toggling cycles with a rise/fall data pair in each, and one clock of strobe postamble. The PHY turns these flags into the strobe and data waveforms.

Write latency comes from two static configuration inputs, additive latency and CAS latency, and is computed in a register stage. After the last beat, a write-recovery counter keeps a precharge to the written bank stalled at its ready/valid handshake until the programmed gap has passed. Precharges to other banks go through at once. Cycles are numbered from the cycle in which the write command sits on the pins, which is cycle 0.

Top module: `dwb_seq`

## Requirements
- R1: In the cycle after a write request is accepted (wr_valid and wr_ready both high at a clock edge), the command pins carry WRITE (cs_n=0, ras_n=1, cas_n=0, we_n=0), mem_ba carries the request's bank, and mem_addr carries the column zero-extended, so that bit 10 is 0.
- R2: In every cycle that holds neither a WRITE nor a PRECHARGE, including reset, the command pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and mem_ba and mem_addr are zero.
- R3: Write latency is WL = AL + CL - 1 (AL 0..4, CL 3..6), taken from the configuration inputs through a register. wr_ready is low during reset and in the first cycle after reset is released.
- R4: phy_dqs_pre and phy_dqs_oe are high in cycle WL-1 and only there among the preamble cycles.
- R5: phy_dqs_tog and phy_dq_oe are high in cycles WL to WL+BL/2-1, where BL is 8 when cfg_bl8=1 and 4 otherwise. In the cycle WL+j, phy_dq_rise carries beat 2j and phy_dq_fall carries beat 2j+1. Beat i is wr_data[8i+7:8i].
- R6: With BL=4, beats 4 to 7 of wr_data are ignored. Whenever phy_dq_oe is low, phy_dq_rise and phy_dq_fall are zero.
- R7: phy_dqs_post and phy_dqs_oe are high for exactly the one cycle after the last beat. After that, phy_dqs_oe and phy_dq_oe are low.
- R8: A precharge request to the written bank is held off: pre_ready stays low until cycle L+tWR, where L = WL+BL/2-1 is the last beat cycle and tWR = cfg_twr (1..15). In the cycle after acceptance, the pins carry PRECHARGE (cs_n=0, ras_n=0, cas_n=1, we_n=0) with that bank on mem_ba and mem_addr zero.
- R9: A precharge to a different bank is accepted during a burst. In a cycle where a write is accepted, pre_ready is low, so the write takes the command slot.
- R10: Once a write is accepted, wr_ready stays low until cycle max(L+2, L+tWR).
- R11: With AL=2, CL=3 and BL=4, the two beat cycles are cycles 4 and 5 after the write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | 3 | Additive latency, 0..4 |
| cfg_cl | input | 3 | CAS latency, 3..6 |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cfg_twr | input | TWR_W (4) | Write-recovery clocks, 1..15 |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with wr_valid |
| wr_bank | input | BA_W (3) | Bank of the write |
| wr_col | input | COL_W (10) | Starting column |
| wr_data | input | BL_MAX*DQ_W (64) | Burst data, beat i in bits 8i+7:8i |
| pre_valid | input | 1 | Precharge request valid |
| pre_ready | output | 1 | Precharge request accepted when high with pre_valid |
| pre_bank | input | BA_W (3) | Bank to precharge |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W (3) | Bank address pins |
| mem_addr | output | ADDR_W (14) | Address pins |
| phy_dqs_oe | output | 1 | Strobe output enable |
| phy_dqs_pre | output | 1 | Strobe preamble cycle (strobe low) |
| phy_dqs_tog | output | 1 | Strobe toggling cycle |
| phy_dqs_post | output | 1 | Strobe postamble cycle (strobe low) |
| phy_dq_oe | output | 1 | Data output enable |
| phy_dq_rise | output | DQ_W (8) | Data on the rising strobe edge |
| phy_dq_fall | output | DQ_W (8) | Data on the falling strobe edge |

## Verification
The command appears one cycle after acceptance. The preamble is due WL-1 cycles after the command, the beats at WL through L, the postamble at L+1, and precharge readiness at L+tWR, with the PRECHARGE itself one cycle later. The bench drives at the falling edge and counts cycles from the command cycle. At each falling edge it compares every flag, data byte and command pin against these offsets, which it computes from AL, CL, BL and tWR. It sweeps all AL, CL and burst-length combinations, so that every latency offset falls on a measured cycle.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } dwb_cmd_t;

   localparam dwb_cmd_t DWB_CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam dwb_cmd_t DWB_CMD_WR  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
   localparam dwb_cmd_t DWB_CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/dwb_lat.sv
// Registered write-latency stage: WL = AL + CL - 1.
module dwb_lat #(
   parameter int WL_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      al,
   input  logic [2:0]      cl,
   output logic [WL_W-1:0] wl_q,
   output logic            wl_vld
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wl_q   <= '0;
         wl_vld <= 1'b0;
      end else begin
         wl_q   <= WL_W'(al) + WL_W'(cl) - WL_W'(1);
         wl_vld <= 1'b1;
      end
   end

endmodule

// File: rtl/dwb_burst.sv
// Burst scheduler: counts from the write command cycle and raises the
// preamble, toggle and postamble flags with the beat pair of each cycle.
module dwb_burst #(
   parameter int DQ_W   = 8,
   parameter int BL_MAX = 8,
   parameter int WL_W   = 4,
   parameter int CNT_W  = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [WL_W-1:0]        wl,
   input  logic                   bl8,
   input  logic [BL_MAX*DQ_W-1:0] data,
   output logic                   busy,
   output logic                   post,
   output logic                   last,
   output logic                   cmd_slot,
   output logic                   dqs_pre,
   output logic                   dqs_tog,
   output logic [DQ_W-1:0]        dq_rise,
   output logic [DQ_W-1:0]        dq_fall
);

   localparam int NB_MAX = BL_MAX / 2;

   logic                   busy_q, post_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [BL_MAX*DQ_W-1:0] data_q;
   logic [CNT_W-1:0]       wl_c, nb, last_idx, rel;
   logic                   in_beat;
   logic [DQ_W-1:0]        rise_sel [NB_MAX];
   logic [DQ_W-1:0]        fall_sel [NB_MAX];

   assign wl_c     = CNT_W'(wl);
   assign nb       = bl8 ? CNT_W'(NB_MAX) : CNT_W'(NB_MAX / 2);
   assign last_idx = wl_c + nb - CNT_W'(1);
   assign rel      = cnt_q - wl_c;
   assign in_beat  = busy_q && (cnt_q >= wl_c) && (cnt_q <= last_idx);

   assign busy     = busy_q;
   assign post     = post_q;
   assign last     = busy_q && (cnt_q == last_idx);
   assign cmd_slot = busy_q && (cnt_q == '0);
   assign dqs_pre  = busy_q && (cnt_q == wl_c - CNT_W'(1));
   assign dqs_tog  = in_beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         post_q <= 1'b0;
         cnt_q  <= '0;
         data_q <= '0;
      end else begin
         post_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            data_q <= data;
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
               post_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   for (genvar b = 0; b < NB_MAX; b++) begin : g_pair
      assign rise_sel[b] = (in_beat && rel == CNT_W'(b)) ? data_q[(2*b)*DQ_W +: DQ_W]   : '0;
      assign fall_sel[b] = (in_beat && rel == CNT_W'(b)) ? data_q[(2*b+1)*DQ_W +: DQ_W] : '0;
   end

   always_comb begin
      dq_rise = '0;
      dq_fall = '0;
      for (int b = 0; b < NB_MAX; b++) begin
         dq_rise = dq_rise | rise_sel[b];
         dq_fall = dq_fall | fall_sel[b];
      end
   end

endmodule

// File: rtl/dwb_rec.sv
// Write-recovery timer and precharge handshake.
module dwb_rec #(
   parameter int BA_W  = 3,
   parameter int TWR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_fire,
   input  logic             burst_busy,
   input  logic             last,
   input  logic [BA_W-1:0]  trk_bank,
   input  logic [TWR_W-1:0] twr,
   input  logic             pre_valid,
   input  logic [BA_W-1:0]  pre_bank,
   output logic             pre_ready,
   output logic             rec_idle,
   output logic             pcmd_q,
   output logic [BA_W-1:0]  pbank_q
);

   logic [TWR_W-1:0] rec_q;
   logic             block;

   assign rec_idle  = (rec_q == '0);
   assign block     = (burst_busy || !rec_idle) && (pre_bank == trk_bank);
   assign pre_ready = !wr_fire && !block;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_q   <= '0;
         pcmd_q  <= 1'b0;
         pbank_q <= '0;
      end else begin
         if (last)
            rec_q <= (twr == '0) ? '0 : twr - TWR_W'(1);
         else if (!rec_idle)
            rec_q <= rec_q - TWR_W'(1);
         pcmd_q  <= pre_valid && pre_ready;
         pbank_q <= pre_bank;
      end
   end

endmodule

// File: rtl/dwb_seq.sv
module dwb_seq #(
   parameter int BA_W   = 3,
   parameter int COL_W  = 10,
   parameter int ADDR_W = 14,
   parameter int DQ_W   = 8,
   parameter int BL_MAX = 8,
   parameter int TWR_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             cfg_al,
   input  logic [2:0]             cfg_cl,
   input  logic                   cfg_bl8,
   input  logic [TWR_W-1:0]       cfg_twr,
   input  logic                   wr_valid,
   output logic                   wr_ready,
   input  logic [BA_W-1:0]        wr_bank,
   input  logic [COL_W-1:0]       wr_col,
   input  logic [BL_MAX*DQ_W-1:0] wr_data,
   input  logic                   pre_valid,
   output logic                   pre_ready,
   input  logic [BA_W-1:0]        pre_bank,
   output logic                   mem_cs_n,
   output logic                   mem_ras_n,
   output logic                   mem_cas_n,
   output logic                   mem_we_n,
   output logic [BA_W-1:0]        mem_ba,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   phy_dqs_oe,
   output logic                   phy_dqs_pre,
   output logic                   phy_dqs_tog,
   output logic                   phy_dqs_post,
   output logic                   phy_dq_oe,
   output logic [DQ_W-1:0]        phy_dq_rise,
   output logic [DQ_W-1:0]        phy_dq_fall
);
   import dwb_pkg::*;

   localparam int WL_W  = 4;
   localparam int CNT_W = $clog2(8 + BL_MAX / 2 + 2) + 1;

   if (BL_MAX != 8) begin : g_bad_bl
      $error("dwb_seq: BL_MAX must be 8");
   end
   if (COL_W > 10 || COL_W >= ADDR_W) begin : g_bad_col
      $error("dwb_seq: column must fit below address bit 10");
   end
   if (TWR_W < 2) begin : g_bad_twr
      $error("dwb_seq: TWR_W too small");
   end

   logic [WL_W-1:0]  wl;
   logic             wl_vld;
   logic             wr_fire;
   logic             busy, post, last, cmd_slot;
   logic             rec_idle, pcmd_q;
   logic [BA_W-1:0]  pbank_q, bank_q;
   logic [COL_W-1:0] col_q;
   dwb_cmd_t         cmd;

   assign wr_ready = wl_vld && !busy && !post && rec_idle;
   assign wr_fire  = wr_valid && wr_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
         col_q  <= '0;
      end else if (wr_fire) begin
         bank_q <= wr_bank;
         col_q  <= wr_col;
      end
   end

   dwb_lat #(.WL_W(WL_W)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .al     (cfg_al),
      .cl     (cfg_cl),
      .wl_q   (wl),
      .wl_vld (wl_vld)
   );

   dwb_burst #(.DQ_W(DQ_W), .BL_MAX(BL_MAX), .WL_W(WL_W), .CNT_W(CNT_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (wr_fire),
      .wl       (wl),
      .bl8      (cfg_bl8),
      .data     (wr_data),
      .busy     (busy),
      .post     (post),
      .last     (last),
      .cmd_slot (cmd_slot),
      .dqs_pre  (phy_dqs_pre),
      .dqs_tog  (phy_dqs_tog),
      .dq_rise  (phy_dq_rise),
      .dq_fall  (phy_dq_fall)
   );

   dwb_rec #(.BA_W(BA_W), .TWR_W(TWR_W)) u_rec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_fire    (wr_fire),
      .burst_busy (busy),
      .last       (last),
      .trk_bank   (bank_q),
      .twr        (cfg_twr),
      .pre_valid  (pre_valid),
      .pre_bank   (pre_bank),
      .pre_ready  (pre_ready),
      .rec_idle   (rec_idle),
      .pcmd_q     (pcmd_q),
      .pbank_q    (pbank_q)
   );

   assign phy_dqs_post = post;
   assign phy_dq_oe    = phy_dqs_tog;
   assign phy_dqs_oe   = phy_dqs_pre | phy_dqs_tog | post;

   always_comb begin
      cmd      = DWB_CMD_NOP;
      mem_ba   = '0;
      mem_addr = '0;
      if (cmd_slot) begin
         cmd      = DWB_CMD_WR;
         mem_ba   = bank_q;
         mem_addr = ADDR_W'(col_q);
      end else if (pcmd_q) begin
         cmd    = DWB_CMD_PRE;
         mem_ba = pbank_q;
      end
   end

   assign mem_cs_n  = cmd.cs_n;
   assign mem_ras_n = cmd.ras_n;
   assign mem_cas_n = cmd.cas_n;
   assign mem_we_n  = cmd.we_n;

endmodule

// File: rtl/dwb_seq_chk.sv
module dwb_seq_chk #(
   parameter int DQ_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_valid,
   input logic            wr_ready,
   input logic            pre_valid,
   input logic            pre_ready,
   input logic            mem_cs_n,
   input logic            mem_ras_n,
   input logic            mem_cas_n,
   input logic            mem_we_n,
   input logic            phy_dqs_oe,
   input logic            phy_dqs_pre,
   input logic            phy_dqs_tog,
   input logic            phy_dqs_post,
   input logic            phy_dq_oe,
   input logic [DQ_W-1:0] phy_dq_rise,
   input logic [DQ_W-1:0] phy_dq_fall
);

   logic [3:0] pins;
   assign pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

   a_r1_write_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> (pins == 4'b0100));

   a_r2_legal_command: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0111) || (pins == 4'b0100) || (pins == 4'b0010));

   a_r4_preamble_then_beat: assert property (@(posedge clk) disable iff (!rst_n)
      phy_dqs_pre |=> phy_dq_oe);

   a_r5_strobe_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      phy_dq_oe |-> (phy_dqs_tog && phy_dqs_oe));

   a_r5_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phy_dqs_pre, phy_dqs_tog, phy_dqs_post}));

   a_r6_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_dq_oe |-> (phy_dq_rise == '0 && phy_dq_fall == '0));

   a_r7_post_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phy_dq_oe) |-> phy_dqs_post);

   a_r7_strobe_released: assert property (@(posedge clk) disable iff (!rst_n)
      phy_dqs_post |=> !phy_dqs_oe);

   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |-> !(pre_valid && pre_ready));

   a_r10_no_write_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      phy_dqs_oe |-> !wr_ready);

endmodule

bind dwb_seq dwb_seq_chk #(.DQ_W(DQ_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_valid     (wr_valid),
   .wr_ready     (wr_ready),
   .pre_valid    (pre_valid),
   .pre_ready    (pre_ready),
   .mem_cs_n     (mem_cs_n),
   .mem_ras_n    (mem_ras_n),
   .mem_cas_n    (mem_cas_n),
   .mem_we_n     (mem_we_n),
   .phy_dqs_oe   (phy_dqs_oe),
   .phy_dqs_pre  (phy_dqs_pre),
   .phy_dqs_tog  (phy_dqs_tog),
   .phy_dqs_post (phy_dqs_post),
   .phy_dq_oe    (phy_dq_oe),
   .phy_dq_rise  (phy_dq_rise),
   .phy_dq_fall  (phy_dq_fall)
);

// File: tb/dwb_seq_tb_top.sv
module dwb_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_al = 3'd0, cfg_cl = 3'd3;
   logic        cfg_bl8 = 1'b0;
   logic [3:0]  cfg_twr = 4'd1;
   logic        wr_valid = 1'b0, pre_valid = 1'b0;
   logic [2:0]  wr_bank = '0, pre_bank = '0;
   logic [9:0]  wr_col = '0;
   logic [63:0] wr_data = '0;
   logic        wr_ready, pre_ready;
   logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
   logic [2:0]  mem_ba;
   logic [13:0] mem_addr;
   logic        phy_dqs_oe, phy_dqs_pre, phy_dqs_tog, phy_dqs_post, phy_dq_oe;
   logic [7:0]  phy_dq_rise, phy_dq_fall;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dwb_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
      .cfg_twr(cfg_twr), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank),
      .wr_col(wr_col), .wr_data(wr_data), .pre_valid(pre_valid), .pre_ready(pre_ready),
      .pre_bank(pre_bank), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
      .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
      .phy_dqs_oe(phy_dqs_oe), .phy_dqs_pre(phy_dqs_pre), .phy_dqs_tog(phy_dqs_tog),
      .phy_dqs_post(phy_dqs_post), .phy_dq_oe(phy_dq_oe), .phy_dq_rise(phy_dq_rise),
      .phy_dq_fall(phy_dq_fall)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] pins();
      return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
   endfunction

   // k counts from the WRITE command cycle; checks run at the falling edge.
   task automatic run_case(input int al, input int cl, input bit bl8, input int twr);
      int wl, nb, last, kp;
      logic [2:0]  bank;
      logic [9:0]  col;
      logic [63:0] data;
      wl = al + cl - 1;
      nb = bl8 ? 4 : 2;
      last = wl + nb - 1;
      kp = last + twr;
      bank = 3'((al + cl) % 8);
      col = 10'($urandom);
      data = {$urandom(), $urandom()};
      @(negedge clk);
      cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = bl8; cfg_twr = 4'(twr);
      repeat (2) @(negedge clk);
      chk("R10", "wr_ready idle", longint'(wr_ready), 1);
      wr_valid = 1'b1; wr_bank = bank; wr_col = col; wr_data = data;
      @(negedge clk);
      wr_valid = 1'b0;
      wr_data = '1;
      for (int k = 0; k <= kp + 1; k++) begin
         if (k > 0) @(negedge clk);
         if (k == 0) begin
            chk("R1", "write pins", longint'(pins()), 4'b0100);
            chk("R1", "write bank", longint'(mem_ba), longint'(bank));
            chk("R1", "write addr", longint'(mem_addr), longint'(col));
         end else if (k == kp + 1) begin
            chk("R8", "precharge pins", longint'(pins()), 4'b0010);
            chk("R8", "precharge bank", longint'(mem_ba), longint'(bank));
            chk("R8", "precharge addr", longint'(mem_addr), 0);
         end else begin
            chk("R2", "nop pins", longint'(pins()), 4'b0111);
            chk("R2", "nop addr", longint'({mem_ba, mem_addr}), 0);
         end
         chk("R4", "preamble", longint'(phy_dqs_pre), longint'(k == wl - 1));
         chk("R5", "toggle", longint'(phy_dqs_tog), longint'(k >= wl && k <= last));
         chk("R5", "dq_oe", longint'(phy_dq_oe), longint'(k >= wl && k <= last));
         chk("R7", "postamble", longint'(phy_dqs_post), longint'(k == last + 1));
         chk("R7", "dqs_oe", longint'(phy_dqs_oe), longint'(k >= wl - 1 && k <= last + 1));
         if (k >= wl && k <= last) begin
            chk("R5", "rise beat", longint'(phy_dq_rise), longint'(data[(2*(k-wl))*8 +: 8]));
            chk("R5", "fall beat", longint'(phy_dq_fall), longint'(data[(2*(k-wl)+1)*8 +: 8]));
         end else begin
            chk("R6", "idle data", longint'({phy_dq_rise, phy_dq_fall}), 0);
         end
         if (al == 2 && cl == 3 && !bl8)
            chk("R11", "worked example beat", longint'(phy_dqs_tog), longint'(k == 4 || k == 5));
         chk("R10", "wr_ready", longint'(wr_ready), longint'(k >= last + 2 && k >= kp));
         if (k >= 1 && k <= kp)
            chk("R8", "pre_ready same bank", longint'(pre_ready), longint'(k == kp));
         if (k == 0) begin
            pre_valid = 1'b1; pre_bank = bank;
         end
         if (k == kp + 1) pre_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R3", "wr_ready in reset", longint'(wr_ready), 0);
      chk("R2", "nop in reset", longint'(pins()), 4'b0111);
      chk("R7", "dqs_oe in reset", longint'(phy_dqs_oe), 0);
      rst_n = 1'b1;
      #1;
      chk("R3", "wr_ready first cycle", longint'(wr_ready), 0);
      @(negedge clk);
      chk("R3", "wr_ready after latency stage", longint'(wr_ready), 1);

      for (int al = 0; al <= 4; al++)
         for (int cl = 3; cl <= 6; cl++)
            for (int b = 0; b < 2; b++)
               run_case(al, cl, bit'(b), ((al * 3 + cl + b) % 6) + 1);

      // Write wins the command slot; other bank precharge goes during the burst.
      @(negedge clk);
      cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0; cfg_twr = 4'd5;
      repeat (2) @(negedge clk);
      wr_valid = 1'b1; wr_bank = 3'd3; wr_col = 10'h155; wr_data = 64'h0123456789abcdef;
      pre_valid = 1'b1; pre_bank = 3'd5;
      #1;
      chk("R9", "pre_ready during write accept", longint'(pre_ready), 0);
      @(negedge clk);
      wr_valid = 1'b0;
      chk("R9", "pre_ready other bank in burst", longint'(pre_ready), 1);
      @(negedge clk);
      pre_valid = 1'b0;
      chk("R9", "other bank precharge pins", longint'(pins()), 4'b0010);
      chk("R9", "other bank precharge ba", longint'(mem_ba), 5);
      @(negedge clk);
      chk("R5", "beat 0 after pre", longint'(phy_dq_rise), 8'hef);
      repeat (20) @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule